// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block is one divider channel of a clock distribution path. It runs on the fast source clock. Its output waveform has a high time and a low time that are set separately, each as a count of source clock cycles. Configuration arrives on parallel static inputs: the two half-period counts, a starting polarity, a phase delay, a bypass selector, a selector that makes the channel deaf to the synchronisation strobe, and a static-high override.

A chip-wide synchronisation strobe re-aligns every channel that obeys it. While the strobe is high, the output sits at its selected starting level. After release, the channel waits a programmable number of source cycles and then counts out its first half period. Several channels given different delays therefore come out of one strobe with a fixed skew between them.

Bypass sends the source clock unchanged to the output and freezes the divider state. The static override holds the output high while it is active. When the override is lifted, the channel restarts from its starting level.

Top module: `clkdiv_hl`

## Requirements
- R1: With `bypass_i`=0 and no override, the output stays low for `lo_cnt_i`+1 source cycles in each period.
- R2: The output stays high for `hi_cnt_i`+1 source cycles in each period, so both counts at 0 give a divide-by-two waveform.
- R3: With `bypass_i`=1, `div_o` equals `clk_i`. The divider state does not advance while bypass is on: after bypass is cleared, the waveform resumes as if the bypassed cycles had been removed.
- R4: With `nosync_i`=1, a `sync_i` pulse has no effect on the running waveform.
- R5: With `nosync_i`=1 and `force_hi_i`=1, `div_o` is 1 at once and stays 1. With `nosync_i`=0, `force_hi_i` has no effect.
- R6: With `bypass_i`=1, `div_o` still follows `clk_i` whatever the values of `force_hi_i` and `nosync_i`.
- R7: During reset, and while `sync_i`=1 with `nosync_i`=0, the output equals `start_hi_i` (1 = start high, 0 = start low).
- R8: Let E0 be the last clock edge that samples `sync_i`=1. The first output transition then occurs at edge E0 + `phase_i` + N + 1, where N is the count of the starting half period.
- R9: A change of `lo_cnt_i` or `hi_cnt_i` in the middle of a half period does not alter that half period. The new values apply from the next transition onward.
- R10: When `force_hi_i` is cleared, the output returns to `start_hi_i` and counts a full starting half period from the last static edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Chip-level synchronisation strobe, active high |
| lo_cnt_i | input | CW | Low half-period count minus one |
| hi_cnt_i | input | CW | High half-period count minus one |
| bypass_i | input | 1 | Route the source clock straight to the output |
| nosync_i | input | 1 | Ignore the synchronisation strobe |
| force_hi_i | input | 1 | Static-high override (needs `nosync_i`) |
| start_hi_i | input | 1 | Starting level after sync or reset |
| phase_i | input | CW | Delay in source cycles after sync release |
| div_o | output | 1 | Divided clock output |

## Verification
Every one of the 256 pairs of low and high counts is measured after a sync. Because the low and high widths are checked separately, swapped or off-by-one fields show up at once. Phase delays of 0, 1, 5 and 15 are tried with a high start, which separates the delay from the half-period count. The remaining tests compare against an expected waveform built from the sync edge. A mid-period count change, a sync pulse while sync is ignored, the override with and without `nosync_i`, and a bypass window each leave a distinct shift or glitch in the output if they are handled wrongly.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    typedef enum logic [1:0] {
        MD_RUN    = 2'd0,
        MD_SYNC   = 2'd1,
        MD_STATIC = 2'd2,
        MD_BYPASS = 2'd3
    } div_mode_e;

    // Priority: bypass over static override over sync over normal running.
    function automatic div_mode_e pick_mode(input logic byp, input logic nsy,
                                            input logic frc, input logic syn);
        div_mode_e m;
        if (byp)              m = MD_BYPASS;
        else if (nsy && frc)  m = MD_STATIC;
        else if (syn && !nsy) m = MD_SYNC;
        else                  m = MD_RUN;
        return m;
    endfunction

endpackage

// File: rtl/clkdiv_mode_dec.sv
`timescale 1ns/1ps
module clkdiv_mode_dec
    import clkdiv_pkg::*;
(
    input  logic      bypass_i,
    input  logic      nosync_i,
    input  logic      force_hi_i,
    input  logic      sync_i,
    output div_mode_e mode_o
);
    always_comb mode_o = pick_mode(bypass_i, nosync_i, force_hi_i, sync_i);
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  div_mode_e     mode_i,
    input  logic [CW-1:0] lo_i,
    input  logic [CW-1:0] hi_i,
    input  logic          start_hi_i,
    input  logic [CW-1:0] phase_i,
    output logic          lvl_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] len_o,
    output logic [CW-1:0] dly_o
);
    logic          lvl;
    logic [CW-1:0] cnt, dly, act_lo, act_hi, len_cur;

    assign len_cur = lvl ? act_hi : act_lo;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lvl    <= start_hi_i;
            cnt    <= '0;
            dly    <= '0;
            act_lo <= lo_i;
            act_hi <= hi_i;
        end else begin
            case (mode_i)
                MD_BYPASS: begin
                    // divider frozen
                end
                MD_STATIC, MD_SYNC: begin
                    lvl    <= start_hi_i;
                    cnt    <= '0;
                    dly    <= (mode_i == MD_SYNC) ? phase_i : '0;
                    act_lo <= lo_i;
                    act_hi <= hi_i;
                end
                default: begin
                    if (dly != '0) begin
                        dly <= dly - 1'b1;
                    end else if (cnt == len_cur) begin
                        lvl    <= ~lvl;
                        cnt    <= '0;
                        act_lo <= lo_i;
                        act_hi <= hi_i;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign lvl_o = lvl;
    assign cnt_o = cnt;
    assign len_o = len_cur;
    assign dly_o = dly;
endmodule

// File: rtl/clkdiv_outsel.sv
`timescale 1ns/1ps
module clkdiv_outsel
    import clkdiv_pkg::*;
(
    input  logic      clk_i,
    input  div_mode_e mode_i,
    input  logic      lvl_i,
    output logic      div_o
);
    always_comb begin
        unique case (mode_i)
            MD_BYPASS: div_o = clk_i;
            MD_STATIC: div_o = 1'b1;
            default:   div_o = lvl_i;
        endcase
    end
endmodule

// File: rtl/clkdiv_hl.sv
`timescale 1ns/1ps
module clkdiv_hl
    import clkdiv_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          sync_i,
    input  logic [CW-1:0] lo_cnt_i,
    input  logic [CW-1:0] hi_cnt_i,
    input  logic          bypass_i,
    input  logic          nosync_i,
    input  logic          force_hi_i,
    input  logic          start_hi_i,
    input  logic [CW-1:0] phase_i,
    output logic          div_o
);
    div_mode_e     mode;
    logic          lvl;
    logic [CW-1:0] cnt, len_cur, dly;

    clkdiv_mode_dec u_dec (
        .bypass_i   (bypass_i),
        .nosync_i   (nosync_i),
        .force_hi_i (force_hi_i),
        .sync_i     (sync_i),
        .mode_o     (mode)
    );

    clkdiv_core #(.CW(CW)) u_core (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mode_i     (mode),
        .lo_i       (lo_cnt_i),
        .hi_i       (hi_cnt_i),
        .start_hi_i (start_hi_i),
        .phase_i    (phase_i),
        .lvl_o      (lvl),
        .cnt_o      (cnt),
        .len_o      (len_cur),
        .dly_o      (dly)
    );

    clkdiv_outsel u_out (
        .clk_i  (clk_i),
        .mode_i (mode),
        .lvl_i  (lvl),
        .div_o  (div_o)
    );
endmodule

// File: rtl/clkdiv_hl_chk.sv
`timescale 1ns/1ps
module clkdiv_hl_chk #(
    parameter int CW = 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          sync_i,
    input logic          bypass_i,
    input logic          nosync_i,
    input logic          force_hi_i,
    input logic          start_hi_i,
    input logic          div_o,
    input logic          lvl,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] len_cur,
    input logic [CW-1:0] dly
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt <= len_cur); // R1

    AST_STATIC_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bypass_i && nosync_i && force_hi_i) |-> div_o); // R5

    AST_BYPASS_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_i |=> ($stable(lvl) && $stable(cnt) && $stable(dly))); // R3

    AST_SYNC_START: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bypass_i && !nosync_i && sync_i) |=> (lvl == $past(start_hi_i))); // R7

    AST_NOSYNC_COUNTS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bypass_i && nosync_i && !force_hi_i && dly == '0 && cnt != len_cur)
        |=> (cnt == CW'($past(cnt) + 1'b1))); // R4

    AST_PHASE_WAIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bypass_i && !(nosync_i && force_hi_i) && !(sync_i && !nosync_i) && dly != '0)
        |=> $stable(lvl)); // R8
endmodule

bind clkdiv_hl clkdiv_hl_chk #(.CW(CW)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sync_i     (sync_i),
    .bypass_i   (bypass_i),
    .nosync_i   (nosync_i),
    .force_hi_i (force_hi_i),
    .start_hi_i (start_hi_i),
    .div_o      (div_o),
    .lvl        (lvl),
    .cnt        (cnt),
    .len_cur    (len_cur),
    .dly        (dly)
);

// File: tb/tb_clkdiv_hl.sv
`timescale 1ns/1ps
module tb_clkdiv_hl;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync = 1'b0;
    logic [CW-1:0] lo = '0, hi = '0, ph = '0;
    logic          byp = 1'b0, nsy = 1'b0, frc = 1'b0, sth = 1'b0;
    logic          div;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_hl #(.CW(CW)) dut (
        .clk_i(clk), .rst_i(rst), .sync_i(sync), .lo_cnt_i(lo), .hi_cnt_i(hi),
        .bypass_i(byp), .nosync_i(nsy), .force_hi_i(frc), .start_hi_i(sth),
        .phase_i(ph), .div_o(div)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected level k posedges after anchor edge E0.
    function automatic int exp_lvl(int k, int st, int p, int l, int h);
        int v = st;
        int t = p + (st != 0 ? h : l) + 1;
        while (k >= t) begin
            v = 1 - v;
            t += (v != 0 ? h : l) + 1;
        end
        return v;
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Sync pulse: returns at sample k=0 (just after E0); sync released at next negedge.
    task automatic anchor();
        @(negedge clk);
        byp = 0; frc = 0; nsy = 0; sync = 1;
        step();
        @(negedge clk);
        sync = 0;
    endtask

    task automatic t_reset();
        rst = 1; sth = 0;
        repeat (3) step();
        check("R7 reset level", div, 0);
        @(negedge clk); rst = 0;
    endtask

    task automatic t_widths();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int nl, nh;
                lo = CW'(a); hi = CW'(b); sth = 0; ph = '0;
                anchor();
                nl = 1;
                step();
                while (div == 1'b0 && nl < 40) begin nl++; step(); end
                nh = 0;
                while (div == 1'b1 && nh < 40) begin nh++; step(); end
                check("R1 low width", nl, a + 1);
                check("R2 high width", nh, b + 1);
            end
        end
    endtask

    task automatic t_start();
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            sth = s[0]; nsy = 0; sync = 1;
            repeat (3) begin step(); check("R7 held at start level", div, s); end
            @(negedge clk); sync = 0;
        end
    endtask

    task automatic t_phase();
        int pv [4] = '{0, 1, 5, 15};
        for (int i = 0; i < 4; i++) begin
            int nh;
            sth = 1; hi = 4'd2; lo = 4'd1; ph = CW'(pv[i]);
            anchor();
            nh = 1;
            step();
            while (div == 1'b1 && nh < 60) begin nh++; step(); end
            check("R8 phase delay plus first high", nh, pv[i] + 3);
        end
        ph = '0; sth = 0;
    endtask

    task automatic t_count_change();
        lo = 4'd3; hi = 4'd3; sth = 0; ph = '0;
        anchor();
        step(); // k=1
        @(negedge clk); lo = 4'd0; hi = 4'd0;
        for (int k = 2; k <= 8; k++) begin
            step();
            check("R9 new counts at boundary", div, (k < 4) ? 0 : ((k % 2 == 0) ? 1 : 0));
        end
    endtask

    task automatic t_nosync();
        lo = 4'd3; hi = 4'd3; sth = 0; ph = '0;
        anchor();
        for (int k = 1; k <= 24; k++) begin
            if (k == 5) begin nsy = 1; sync = 1; end
            if (k == 7) sync = 0;
            step();
            check("R4 sync ignored", div, exp_lvl(k, 0, 0, 3, 3));
            @(negedge clk);
        end
        nsy = 0;
    endtask

    task automatic t_force_no_nosync();
        lo = 4'd2; hi = 4'd1; sth = 0; ph = '0;
        anchor();
        for (int k = 1; k <= 14; k++) begin
            if (k == 3) frc = 1;
            if (k == 11) frc = 0;
            step();
            check("R5 force without nosync ignored", div, exp_lvl(k, 0, 0, 2, 1));
            @(negedge clk);
        end
    endtask

    task automatic t_static();
        lo = 4'd1; hi = 4'd1; sth = 0; ph = '0;
        anchor();
        nsy = 1; frc = 1;
        #1 check("R5 static high immediate", div, 1);
        repeat (4) begin step(); check("R5 static high held", div, 1); end
        @(negedge clk); frc = 0;
        #1 check("R10 back to start level", div, 0);
        for (int k = 1; k <= 8; k++) begin
            step();
            check("R10 resume after static", div, exp_lvl(k, 0, 0, 1, 1));
        end
        @(negedge clk); nsy = 0;
    endtask

    task automatic t_bypass();
        lo = 4'd2; hi = 4'd2; sth = 0; ph = '0;
        anchor();
        step(); step(); // k=2
        @(negedge clk); byp = 1; nsy = 1; frc = 1;
        #1 check("R6 bypass low phase with force", div, 0);
        for (int m = 0; m < 4; m++) begin
            step();
            check("R3 bypass follows clock high", div, 1);
            @(negedge clk); #1;
            check("R6 bypass follows clock low", div, 0);
        end
        byp = 0; nsy = 0; frc = 0;
        for (int j = 1; j <= 6; j++) begin
            step();
            check("R3 resume after bypass", div, exp_lvl(2 + j, 0, 0, 2, 2));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_widths();
        t_start();
        t_phase();
        t_count_change();
        t_nosync();
        t_force_no_nosync();
        t_static();
        t_bypass();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule